// File: doc/BRIEF.md
# Tagged Receive Queue for a Serial Channel

This block is the back end of an asynchronous serial receiver. A bit sampler, outside this block, hands it each finished character on a one-cycle strobe, together with the parity and framing error flags for that character and the current level of the serial line. The block queues characters in an eight-entry FIFO in which every entry keeps its own status flags. A CPU register interface sees the oldest entry's data and flags, a ready flag, a full flag, an overrun flag and a break-change interrupt flag.

A break (the line held at space) is stored as a single zero byte tagged with its own break flag, so software can tell it from a real zero byte. The break is caught even when the line drops partway through a character: any character whose stop bit fails while the line is still at space counts as a break, whatever data bits were sampled. While the break lasts, further strobes are ignored. Its start and its end each raise the break-change flag. In block mode the reported error flags are the OR of all characters accepted since the last reset-error command, and not the head entry's flags.

Top module: `rx_tag_fifo`

## Requirements
- R1: After reset `rx_ready`, `fifo_full`, `stat_ovr`, `cob_irq`, `stat_perr`, `stat_ferr` and `stat_brk` are all 0.
- R2: Accepted characters leave in arrival order. With `blk_mode`=0, `rd_data`, `stat_perr`, `stat_ferr` and `stat_brk` show the oldest entry's own values (all flags 0 when the FIFO is empty). A `data_rd` pulse removes that entry at the clock edge.
- R3: `rx_ready` is 1 from the cycle after a character is accepted. It returns to 0 only after a `data_rd` that leaves the FIFO empty. A `data_rd` on an empty FIFO has no effect.
- R4: While no `data_rd` is given, the head data and flags stay unchanged, even when new characters are accepted behind it.
- R5: A strobe with `char_ferr`=1 while `line_lvl`=0 starts a break. One entry is stored with data 0x00, `stat_brk`=1, `stat_ferr`=1 and `stat_perr`=0, whatever `char_data` held. A real zero byte is stored with `stat_brk`=0.
- R6: During a break, character strobes are ignored. The break ends on the first cycle in which `line_lvl` is 1.
- R7: `cob_irq` is set one cycle after a break starts and one cycle after it ends. It is cleared by command code 0x05. A break event in the same cycle as the clear wins.
- R8: With `blk_mode`=1, the three status outputs give the OR of the flags of every character accepted since the last command 0x04. A character accepted in the same cycle as that command is included.
- R9: `fifo_full` is 1 exactly when 8 entries are held.
- R10: A character that arrives while the FIFO holds 8 entries is dropped, even if a read happens in the same cycle, and `stat_ovr` goes to 1. `stat_ovr` stays set until command 0x04.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| char_valid | input | 1 | One-cycle strobe: a character is complete |
| char_data | input | 8 | Assembled character |
| char_perr | input | 1 | Parity error for this character |
| char_ferr | input | 1 | Framing error (stop bit sampled at space) |
| line_lvl | input | 1 | Current serial line level, 1 = mark |
| data_rd | input | 1 | CPU read of the data location; pops the head |
| blk_mode | input | 1 | 1 selects accumulated error view |
| cmd_valid | input | 1 | Command strobe |
| cmd_code | input | 8 | Command: 0x04 reset errors, 0x05 clear break change |
| rd_data | output | 8 | Head entry data |
| stat_perr | output | 1 | Parity error (head or accumulated) |
| stat_ferr | output | 1 | Framing error (head or accumulated) |
| stat_brk | output | 1 | Break tag (head or accumulated) |
| stat_ovr | output | 1 | Sticky overrun |
| rx_ready | output | 1 | FIFO holds at least one entry |
| fifo_full | output | 1 | FIFO holds 8 entries |
| cob_irq | output | 1 | Break change interrupt flag |

## Verification
The hardest case to reach is a break that arrives while the FIFO is full, combined with a read in the same cycle and a clear command in the same cycle. The break must still start and raise `cob_irq`, but its zero entry is dropped as an overrun. The stimulus fills the FIFO to eight entries, keeps pushing while popping, and then drops the line with a damaged non-zero character. This shows that the break detector and the storage path act independently. The start and end of the break are spread over separate cycles, with extra strobes held in between, so each event edge is seen on its own.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
    localparam int DATA_W = 8;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              perr;
        logic              ferr;
        logic              brk;
    } rxq_ent_t;

    localparam logic [7:0] CMD_RST_ERR = 8'h04;
    localparam logic [7:0] CMD_CLR_COB = 8'h05;
endpackage

// File: rtl/rxq_brk.sv
module rxq_brk
    import rxq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              char_valid,
    input  logic [DATA_W-1:0] char_data,
    input  logic              char_perr,
    input  logic              char_ferr,
    input  logic              line_lvl,
    output logic              push,
    output rxq_ent_t          push_ent,
    output logic              brk_evt
);
    typedef struct packed {
        logic in_brk;
    } brk_st_t;

    brk_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        push     = 1'b0;
        push_ent = '0;
        brk_evt  = 1'b0;
        if (st_q.in_brk) begin
            if (line_lvl) begin
                st_d.in_brk = 1'b0;
                brk_evt     = 1'b1;
            end
        end else if (char_valid) begin
            push = 1'b1;
            if (char_ferr && !line_lvl) begin
                st_d.in_brk   = 1'b1;
                brk_evt       = 1'b1;
                push_ent.data = '0;
                push_ent.perr = 1'b0;
                push_ent.ferr = 1'b1;
                push_ent.brk  = 1'b1;
            end else begin
                push_ent.data = char_data;
                push_ent.perr = char_perr;
                push_ent.ferr = char_ferr;
                push_ent.brk  = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/rxq_store.sv
module rxq_store
    import rxq_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     push,
    input  rxq_ent_t push_ent,
    input  logic     pop_req,
    output rxq_ent_t head,
    output logic     not_empty,
    output logic     full,
    output logic     accepted,
    output logic     dropped
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

    typedef struct packed {
        rxq_ent_t [DEPTH-1:0] mem;
        logic [PTR_W-1:0]     wr_ptr;
        logic [PTR_W-1:0]     rd_ptr;
        logic [CNT_W-1:0]     count;
    } store_st_t;

    store_st_t st_d, st_q;
    logic      pop_ok;

    always_comb begin
        st_d      = st_q;
        full      = (st_q.count == CNT_FULL);
        not_empty = (st_q.count != '0);
        accepted  = push && !full;
        dropped   = push && full;
        pop_ok    = pop_req && not_empty;
        head      = st_q.mem[st_q.rd_ptr];
        if (accepted) begin
            st_d.mem[st_q.wr_ptr] = push_ent;
            st_d.wr_ptr = (st_q.wr_ptr == PTR_LAST) ? '0 : st_q.wr_ptr + 1'b1;
        end
        if (pop_ok) begin
            st_d.rd_ptr = (st_q.rd_ptr == PTR_LAST) ? '0 : st_q.rd_ptr + 1'b1;
        end
        case ({accepted, pop_ok})
            2'b10:   st_d.count = st_q.count + 1'b1;
            2'b01:   st_d.count = st_q.count - 1'b1;
            default: st_d.count = st_q.count;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/rxq_stat.sv
module rxq_stat
    import rxq_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     accepted,
    input  logic     dropped,
    input  rxq_ent_t push_ent,
    input  logic     clr_err,
    input  logic     clr_cob,
    input  logic     brk_evt,
    output logic     acc_perr,
    output logic     acc_ferr,
    output logic     acc_brk,
    output logic     ovr,
    output logic     cob
);
    typedef struct packed {
        logic perr;
        logic ferr;
        logic brk;
        logic ovr;
        logic cob;
    } stat_st_t;

    stat_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_err) begin
            st_d.perr = 1'b0;
            st_d.ferr = 1'b0;
            st_d.brk  = 1'b0;
            st_d.ovr  = 1'b0;
        end
        if (accepted) begin
            st_d.perr = st_d.perr | push_ent.perr;
            st_d.ferr = st_d.ferr | push_ent.ferr;
            st_d.brk  = st_d.brk  | push_ent.brk;
        end
        if (dropped) st_d.ovr = 1'b1;
        if (clr_cob) st_d.cob = 1'b0;
        if (brk_evt) st_d.cob = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign acc_perr = st_q.perr;
    assign acc_ferr = st_q.ferr;
    assign acc_brk  = st_q.brk;
    assign ovr      = st_q.ovr;
    assign cob      = st_q.cob;
endmodule

// File: rtl/rx_tag_fifo.sv
module rx_tag_fifo
    import rxq_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              char_valid,
    input  logic [DATA_W-1:0] char_data,
    input  logic              char_perr,
    input  logic              char_ferr,
    input  logic              line_lvl,
    input  logic              data_rd,
    input  logic              blk_mode,
    input  logic              cmd_valid,
    input  logic [7:0]        cmd_code,
    output logic [DATA_W-1:0] rd_data,
    output logic              stat_perr,
    output logic              stat_ferr,
    output logic              stat_brk,
    output logic              stat_ovr,
    output logic              rx_ready,
    output logic              fifo_full,
    output logic              cob_irq
);
    logic     push, brk_evt, accepted, dropped, not_empty;
    logic     clr_err, clr_cob;
    logic     acc_perr, acc_ferr, acc_brk;
    rxq_ent_t push_ent, head;

    assign clr_err = cmd_valid && (cmd_code == CMD_RST_ERR);
    assign clr_cob = cmd_valid && (cmd_code == CMD_CLR_COB);

    rxq_brk u_brk (
        .clk(clk), .rst_n(rst_n), .char_valid(char_valid), .char_data(char_data),
        .char_perr(char_perr), .char_ferr(char_ferr), .line_lvl(line_lvl),
        .push(push), .push_ent(push_ent), .brk_evt(brk_evt)
    );

    rxq_store #(.DEPTH(DEPTH)) u_store (
        .clk(clk), .rst_n(rst_n), .push(push), .push_ent(push_ent), .pop_req(data_rd),
        .head(head), .not_empty(not_empty), .full(fifo_full),
        .accepted(accepted), .dropped(dropped)
    );

    rxq_stat u_stat (
        .clk(clk), .rst_n(rst_n), .accepted(accepted), .dropped(dropped),
        .push_ent(push_ent), .clr_err(clr_err), .clr_cob(clr_cob), .brk_evt(brk_evt),
        .acc_perr(acc_perr), .acc_ferr(acc_ferr), .acc_brk(acc_brk),
        .ovr(stat_ovr), .cob(cob_irq)
    );

    always_comb begin
        rx_ready = not_empty;
        rd_data  = head.data;
        if (blk_mode) begin
            stat_perr = acc_perr;
            stat_ferr = acc_ferr;
            stat_brk  = acc_brk;
        end else begin
            stat_perr = not_empty && head.perr;
            stat_ferr = not_empty && head.ferr;
            stat_brk  = not_empty && head.brk;
        end
    end
endmodule

// File: rtl/rx_tag_fifo_chk.sv
module rx_tag_fifo_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       data_rd,
    input logic       blk_mode,
    input logic       cmd_valid,
    input logic [7:0] cmd_code,
    input logic [7:0] rd_data,
    input logic       stat_brk,
    input logic       stat_ovr,
    input logic       rx_ready,
    input logic       fifo_full,
    input logic       cob_irq,
    input logic       brk_evt,
    input logic       acc_perr
);
    // R9
    full_has_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_full |-> rx_ready);

    // R3
    ready_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ready && !data_rd |=> rx_ready);

    // R10
    ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat_ovr && !(cmd_valid && cmd_code == 8'h04) |=> stat_ovr);

    // R7
    cob_on_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        brk_evt |=> cob_irq);

    // R5
    brk_is_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !blk_mode && stat_brk |-> rd_data == 8'h00);

    // R8
    acc_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_perr && !(cmd_valid && cmd_code == 8'h04) |=> acc_perr);
endmodule

bind rx_tag_fifo rx_tag_fifo_chk u_chk (
    .clk(clk), .rst_n(rst_n), .data_rd(data_rd), .blk_mode(blk_mode),
    .cmd_valid(cmd_valid), .cmd_code(cmd_code), .rd_data(rd_data),
    .stat_brk(stat_brk), .stat_ovr(stat_ovr), .rx_ready(rx_ready),
    .fifo_full(fifo_full), .cob_irq(cob_irq), .brk_evt(brk_evt), .acc_perr(acc_perr)
);

// File: tb/sim_rx_tag_fifo.sv
module sim_rx_tag_fifo;
    localparam time CLK_PERIOD = 10ns;
    localparam int  DEPTH      = 8;

    logic clk = 0;
    logic rst_n = 0;
    logic cv = 0, cp = 0, cf = 0, line = 1, rd = 0, bm = 0, cmdv = 0;
    logic [7:0] cd = 0, cmdc = 0;
    logic [7:0] rd_data;
    logic stat_perr, stat_ferr, stat_brk, stat_ovr, rx_ready, fifo_full, cob_irq;

    int checks = 0, errors = 0, cycles = 0;

    // reference model: entry packed as {data, perr, ferr, brk}
    logic [10:0] q[$];
    bit m_in_brk = 0, m_ovr = 0, m_cob = 0;
    bit [2:0] m_acc = 0;

    rx_tag_fifo #(.DEPTH(DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n), .char_valid(cv), .char_data(cd), .char_perr(cp),
        .char_ferr(cf), .line_lvl(line), .data_rd(rd), .blk_mode(bm),
        .cmd_valid(cmdv), .cmd_code(cmdc), .rd_data(rd_data), .stat_perr(stat_perr),
        .stat_ferr(stat_ferr), .stat_brk(stat_brk), .stat_ovr(stat_ovr),
        .rx_ready(rx_ready), .fifo_full(fifo_full), .cob_irq(cob_irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic model_step();
        bit evt = 0, push = 0, full;
        logic [10:0] ent = 0;
        full = (q.size() == DEPTH);
        if (m_in_brk) begin
            if (line) begin m_in_brk = 0; evt = 1; end
        end else if (cv) begin
            push = 1;
            if (cf && !line) begin
                ent = {8'h00, 1'b0, 1'b1, 1'b1};
                m_in_brk = 1; evt = 1;
            end else ent = {cd, cp, cf, 1'b0};
        end
        if (cmdv && cmdc == 8'h04) begin m_acc = 0; m_ovr = 0; end
        if (cmdv && cmdc == 8'h05) m_cob = 0;
        if (evt) m_cob = 1;
        if (rd && q.size() > 0) void'(q.pop_front());
        if (push) begin
            if (full) m_ovr = 1;
            else begin q.push_back(ent); m_acc |= ent[2:0]; end
        end
    endtask

    task automatic compare();
        bit [2:0] ef;
        chk(rx_ready == (q.size() > 0), "R3", "rx_ready", rx_ready, q.size() > 0);
        chk(fifo_full == (q.size() == DEPTH), "R9", "fifo_full", fifo_full, q.size() == DEPTH);
        chk(stat_ovr == m_ovr, "R10", "stat_ovr", stat_ovr, m_ovr);
        chk(cob_irq == m_cob, "R7", "cob_irq", cob_irq, m_cob);
        if (bm) begin
            chk({stat_perr, stat_ferr, stat_brk} == m_acc, "R8", "acc flags",
                {stat_perr, stat_ferr, stat_brk}, m_acc);
        end else begin
            ef = (q.size() > 0) ? q[0][2:0] : 3'b000;
            chk({stat_perr, stat_ferr, stat_brk} == ef, "R2", "head flags",
                {stat_perr, stat_ferr, stat_brk}, ef);
            if (q.size() > 0)
                chk(rd_data == q[0][10:3], "R2", "head data", rd_data, q[0][10:3]);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare();
    endtask

    task automatic send(input logic [7:0] d, input logic p, input logic f, input logic l);
        cv = 1; cd = d; cp = p; cf = f; line = l;
        cyc();
        cv = 0; cp = 0; cf = 0;
    endtask

    task automatic read1();
        rd = 1; cyc(); rd = 0;
    endtask

    task automatic cmd(input logic [7:0] c);
        cmdv = 1; cmdc = c; cyc(); cmdv = 0; cmdc = 0;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 20000) begin
                errors++; checks++;
                $display("FAIL watchdog expired");
                $display("  CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        logic [7:0] hd;
        bit [2:0] hf;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk({rx_ready, fifo_full, stat_ovr, cob_irq, stat_perr, stat_ferr, stat_brk} == 0,
            "R1", "reset outputs",
            {rx_ready, fifo_full, stat_ovr, cob_irq, stat_perr, stat_ferr, stat_brk}, 0);
        rst_n = 1;
        cyc();

        // mixed characters, including a genuine zero byte
        send(8'h41, 0, 0, 1);
        send(8'h00, 0, 0, 1);
        send(8'hA5, 1, 0, 1);
        send(8'h7E, 0, 1, 1);   // framing error with line at mark: not a break
        // R4: head stays while status is only observed and more data arrives
        hd = rd_data; hf = {stat_perr, stat_ferr, stat_brk};
        cyc(); cyc();
        send(8'h12, 0, 0, 1);
        chk(rd_data == hd && {stat_perr, stat_ferr, stat_brk} == hf, "R4", "head stable",
            rd_data, hd);
        read1();
        chk(rd_data == 8'h00 && !stat_brk, "R5", "genuine zero untagged", stat_brk, 0);
        repeat (4) read1();
        read1();   // R3 read on empty ignored
        chk(!rx_ready, "R3", "empty after reads", rx_ready, 0);

        // fill, overrun, pop while full
        for (int i = 0; i < DEPTH; i++) send(8'h80 + 8'(i), 1'(i == 3), 0, 1);
        chk(fifo_full, "R9", "full at 8", fifo_full, 1);
        send(8'hEE, 0, 1, 1);   // R10 dropped
        rd = 1; send(8'hEF, 0, 0, 1); rd = 0;   // pop and push at full: push dropped
        chk(stat_ovr, "R10", "overrun sticky", stat_ovr, 1);
        bm = 1; cyc();
        cmdv = 1; cmdc = 8'h04; send(8'h33, 0, 1, 1); cmdv = 0; cmdc = 0;   // R8 same-cycle include
        chk(stat_ferr && !stat_perr, "R8", "acc after clear", {stat_perr, stat_ferr}, 2'b01);
        bm = 0;
        for (int i = 0; i < DEPTH; i++) read1();
        cyc();

        // break beginning mid-character
        send(8'h3C, 0, 1, 0);
        chk(rd_data == 8'h00 && stat_brk && stat_ferr && !stat_perr, "R5", "break entry",
            {rd_data, stat_perr, stat_ferr, stat_brk}, 11'h003);
        send(8'h00, 0, 1, 0);   // R6 ignored during break
        send(8'h55, 1, 0, 0);
        cmd(8'h05);
        line = 0; cyc();
        line = 1; cyc();        // break ends, cob set again
        chk(cob_irq, "R7", "break end event", cob_irq, 1);
        read1();
        chk(!rx_ready, "R6", "only one break entry", rx_ready, 0);
        cmd(8'h05);
        chk(!cob_irq, "R7", "cob cleared", cob_irq, 1'b0);

        // break while full, with read and clear in the same cycle
        for (int i = 0; i < DEPTH; i++) send(8'h10 + 8'(i), 0, 0, 1);
        rd = 1; cmdv = 1; cmdc = 8'h05; send(8'h99, 0, 1, 0);
        rd = 0; cmdv = 0; cmdc = 0;
        chk(cob_irq && stat_ovr, "R7", "break at full still signalled",
            {cob_irq, stat_ovr}, 2'b11);
        line = 1; cyc();
        bm = 1; cyc(); bm = 0;
        for (int i = 0; i < DEPTH; i++) read1();
        cmd(8'h04);
        chk(!stat_ovr, "R10", "overrun cleared", stat_ovr, 0);
        cyc();

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule